// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block arbitrates among eight interrupt request lines. Each line is captured as either a rising-edge event or a live level, chosen per line. Requests that are not masked compete against the lines currently in service. Priority is relative to a programmable rotation offset: the line equal to the offset ranks highest, and rank falls line by line, wrapping modulo eight.

The block raises a registered interrupt output only when the best pending request strictly outranks the best in-service line. It also presents the number of the winning line. A single command port carries decoded operations from the surrounding logic, each with a line operand: acknowledge, non-specific end-of-interrupt with or without rotation, specific end-of-interrupt, set priority, and specific rotate. Configuration inputs select auto end-of-interrupt, rotation on auto end-of-interrupt, and a special nested mode. On a master instance, that mode stops in-service line 2, the cascade input, from blocking further requests.

Top module: `rotpri_core`

## Requirements
- R1: After reset, irq_out is 0 and irq_line is 0. Request, mask and in-service state are all clear, and the rotation offset is 0.
- R2: A line with trig_level bit 0 (edge mode) becomes pending on a 0-to-1 change of its input. It stays pending after the input falls. An input held high raises no new request until it has dropped and risen again.
- R3: A line with trig_level bit 1 (level mode) is pending exactly while its input is high. Acknowledging it does not clear the pending state.
- R4: A line whose mask bit is 1 never causes irq_out. mask_we loads mask_wdata into the mask. A request that was captured while masked is raised once it is unmasked.
- R5: Among unmasked pending lines, the winner is the first line found scanning offset, offset+1, … modulo 8. irq_line reports that line number.
- R6: irq_out is raised only if the winning pending line strictly outranks the highest-ranked in-service line. Equal or lower rank keeps irq_out low.
- R7: With cfg_sfnm and cfg_master both 1, in-service line 2 is left out of the in-service comparison. With either input at 0, line 2 blocks as usual.
- R8: Acknowledge (cmd_op 1) acts only while irq_out is 1. Without auto end-of-interrupt it marks irq_line as in service, and it clears that line's request if the line is in edge mode. irq_out falls in the next cycle.
- R9: With cfg_auto_eoi 1, acknowledge does not mark the line as in service. If cfg_rot_aeoi is also 1, the offset becomes (line+1) mod 8.
- R10: Non-specific end-of-interrupt (cmd_op 2) clears the highest-ranked in-service line. cmd_op 3 does the same and also sets the offset to (that line+1) mod 8.
- R11: cmd_op 4 clears in-service line cmd_line. cmd_op 5 sets the offset to (cmd_line+1) mod 8. cmd_op 6 does both. cmd_op 0 and 7 have no effect.
- R12: While irq_out is 1, irq_line does not change until an acknowledge or until irq_out falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw request inputs |
| trig_level | input | 8 | Per-line mode: 1 level, 0 edge |
| mask_we | input | 1 | Load strobe for the mask |
| mask_wdata | input | 8 | New mask value, 1 masks a line |
| cfg_auto_eoi | input | 1 | Acknowledge ends service at once |
| cfg_rot_aeoi | input | 1 | Rotate offset on auto end-of-interrupt |
| cfg_sfnm | input | 1 | Special nested mode enable |
| cfg_master | input | 1 | Instance is the master (line 2 is cascade) |
| cmd_op | input | 3 | Decoded command code, 0 idle |
| cmd_line | input | 3 | Line operand of the command |
| irq_out | output | 1 | Registered interrupt request |
| irq_line | output | 3 | Line number of the presented request |

## Verification
The assertions assume that cmd_op carries one command per cycle. They also assume that configuration inputs do not change in the same cycle as an acknowledge. The assertion on held line numbers assumes that an acknowledge follows a raised irq_out rather than coinciding with its rising edge. The stimulus drives every input at the falling clock edge and leaves several idle cycles after each command. It changes configuration only while no command is in flight, so each checked output reflects settled state.

// File: rtl/rotpri_pkg.sv
package rotpri_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_ACK      = 3'd1,
        OP_EOI      = 3'd2,
        OP_EOI_ROT  = 3'd3,
        OP_EOI_SPEC = 3'd4,
        OP_SET_PRI  = 3'd5,
        OP_ROT_SPEC = 3'd6,
        OP_RSVD     = 3'd7
    } rp_op_e;

endpackage

// File: rtl/rotpri_scan.sv
// Finds the relative rank of the first set bit of vec, scanning from off upward
// with wrap. Returns NLINES when no bit is set.
module rotpri_scan #(
    parameter int unsigned NLINES = 8,
    localparam int unsigned IDW = $clog2(NLINES),
    localparam int unsigned PW  = IDW + 1
) (
    input  logic [NLINES-1:0] vec,
    input  logic [IDW-1:0]    off,
    output logic [PW-1:0]     rank
);
    always_comb begin
        rank = PW'(NLINES);
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (vec[IDW'(i) + off]) begin
                rank = PW'(i);
            end
        end
    end
endmodule

// File: rtl/rotpri_capture.sv
// Next-state of the request register: edge lines latch rising edges and
// honour the acknowledge clear, level lines copy the input.
module rotpri_capture #(
    parameter int unsigned NLINES = 8
) (
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] trig_level,
    input  logic [NLINES-1:0] prev_q,
    input  logic [NLINES-1:0] irr_q,
    input  logic [NLINES-1:0] clr,
    output logic [NLINES-1:0] irr_nxt
);
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        assign irr_nxt[g] = trig_level[g] ? irq_in[g]
                          : ((irr_q[g] & ~clr[g]) | (irq_in[g] & ~prev_q[g]));
    end
endmodule

// File: rtl/rotpri_core.sv
module rotpri_core
    import rotpri_pkg::*;
#(
    parameter int unsigned NLINES    = 8,
    parameter int unsigned CASC_LINE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NLINES-1:0]          irq_in,
    input  logic [NLINES-1:0]          trig_level,
    input  logic                       mask_we,
    input  logic [NLINES-1:0]          mask_wdata,
    input  logic                       cfg_auto_eoi,
    input  logic                       cfg_rot_aeoi,
    input  logic                       cfg_sfnm,
    input  logic                       cfg_master,
    input  logic [2:0]                 cmd_op,
    input  logic [$clog2(NLINES)-1:0]  cmd_line,
    output logic                       irq_out,
    output logic [$clog2(NLINES)-1:0]  irq_line
);
    localparam int unsigned IDW = $clog2(NLINES);
    localparam int unsigned PW  = IDW + 1;

    typedef struct packed {
        logic [NLINES-1:0] irr;
        logic [NLINES-1:0] imr;
        logic [NLINES-1:0] isr;
        logic [NLINES-1:0] prev;
        logic [IDW-1:0]    off;
        logic [IDW-1:0]    line;
        logic              out;
    } rp_state_t;

    rp_state_t s_q, s_d;

    function automatic logic [NLINES-1:0] line_oh(input logic [IDW-1:0] l);
        logic [NLINES-1:0] v;
        v    = '0;
        v[l] = 1'b1;
        return v;
    endfunction

    rp_op_e            op;
    logic              ack_fire;
    logic              want;
    logic [NLINES-1:0] cand;
    logic [NLINES-1:0] isr_eff;
    logic [NLINES-1:0] ack_clr;
    logic [NLINES-1:0] irr_cap;
    logic [PW-1:0]     pend_rank;
    logic [PW-1:0]     serv_rank;
    logic [PW-1:0]     top_rank;
    logic [IDW-1:0]    win_line;
    logic [IDW-1:0]    top_line;

    assign op       = rp_op_e'(cmd_op);
    assign ack_fire = (op == OP_ACK) && s_q.out;
    assign cand     = s_q.irr & ~s_q.imr;

    always_comb begin
        isr_eff = s_q.isr;
        if (cfg_sfnm && cfg_master) begin
            isr_eff[CASC_LINE] = 1'b0;
        end
    end

    assign ack_clr = ack_fire ? (line_oh(s_q.line) & ~trig_level) : '0;

    rotpri_scan #(.NLINES(NLINES)) u_pend (.vec(cand),    .off(s_q.off), .rank(pend_rank));
    rotpri_scan #(.NLINES(NLINES)) u_serv (.vec(isr_eff), .off(s_q.off), .rank(serv_rank));
    rotpri_scan #(.NLINES(NLINES)) u_top  (.vec(s_q.isr), .off(s_q.off), .rank(top_rank));

    rotpri_capture #(.NLINES(NLINES)) u_cap (
        .irq_in    (irq_in),
        .trig_level(trig_level),
        .prev_q    (s_q.prev),
        .irr_q     (s_q.irr),
        .clr       (ack_clr),
        .irr_nxt   (irr_cap)
    );

    assign want     = pend_rank < serv_rank;
    assign win_line = pend_rank[IDW-1:0] + s_q.off;
    assign top_line = top_rank[IDW-1:0] + s_q.off;

    always_comb begin
        s_d      = s_q;
        s_d.irr  = irr_cap;
        s_d.prev = irq_in;
        if (mask_we) begin
            s_d.imr = mask_wdata;
        end
        unique case (op)
            OP_ACK: begin
                if (ack_fire) begin
                    if (!cfg_auto_eoi) begin
                        s_d.isr = s_q.isr | line_oh(s_q.line);
                    end else if (cfg_rot_aeoi) begin
                        s_d.off = s_q.line + 1'b1;
                    end
                end
            end
            OP_EOI, OP_EOI_ROT: begin
                if (top_rank != PW'(NLINES)) begin
                    s_d.isr = s_q.isr & ~line_oh(top_line);
                    if (op == OP_EOI_ROT) begin
                        s_d.off = top_line + 1'b1;
                    end
                end
            end
            OP_EOI_SPEC: s_d.isr = s_q.isr & ~line_oh(cmd_line);
            OP_SET_PRI:  s_d.off = cmd_line + 1'b1;
            OP_ROT_SPEC: begin
                s_d.isr = s_q.isr & ~line_oh(cmd_line);
                s_d.off = cmd_line + 1'b1;
            end
            default: ;
        endcase
        s_d.out  = want && !ack_fire;
        s_d.line = (want && !s_q.out) ? win_line : s_q.line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_out  = s_q.out;
    assign irq_line = s_q.line;

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        |(irq_in & ~s_q.prev & ~trig_level) |=>
        ((s_q.irr & $past(irq_in & ~s_q.prev & ~trig_level)) == $past(irq_in & ~s_q.prev & ~trig_level))); // R2
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((s_q.irr ^ $past(irq_in)) & $past(trig_level)) == '0)); // R3
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.irr & ~s_q.imr) == '0) |=> !irq_out); // R4
    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !cfg_auto_eoi) |=> s_q.isr[$past(irq_line)]); // R8
    AST_EOI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EOI && s_q.isr != '0) |=> ($countones(s_q.isr) == $countones($past(s_q.isr)) - 1)); // R10
    AST_SET_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET_PRI) |=> (s_q.off == IDW'($past(cmd_line) + 1'b1))); // R11
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out && !ack_fire) |=> (!irq_out || $stable(irq_line))); // R12
endmodule

// File: tb/rotpri_core_tb_top.sv
module rotpri_core_tb_top;
    localparam int OP_ACK = 1, OP_EOI = 2, OP_EOI_ROT = 3, OP_EOI_SPEC = 4,
                   OP_SET_PRI = 5, OP_ROT_SPEC = 6, OP_RSVD = 7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in, trig_level, mask_wdata;
    logic       mask_we, cfg_auto_eoi, cfg_rot_aeoi, cfg_sfnm, cfg_master;
    logic [2:0] cmd_op, cmd_line;
    logic       irq_out;
    logic [2:0] irq_line;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rotpri_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .cfg_auto_eoi(cfg_auto_eoi),
        .cfg_rot_aeoi(cfg_rot_aeoi), .cfg_sfnm(cfg_sfnm), .cfg_master(cfg_master),
        .cmd_op(cmd_op), .cmd_line(cmd_line), .irq_out(irq_out), .irq_line(irq_line)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_irq(input string tag, input int o, input int l);
        chk({tag, " out"}, int'(irq_out), o);
        if (o != 0) chk({tag, " line"}, int'(irq_line), l);
    endtask

    task automatic pulse(input logic [7:0] lines);
        irq_in = irq_in | lines;
        tick(1);
        irq_in = irq_in & ~lines;
        tick(3);
    endtask

    task automatic cmd(input int op, input int l);
        cmd_op   = 3'(op);
        cmd_line = 3'(l);
        tick(1);
        cmd_op   = '0;
        tick(3);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; irq_in = '0; trig_level = '0; mask_we = 1'b0; mask_wdata = '0;
        cfg_auto_eoi = 1'b0; cfg_rot_aeoi = 1'b0; cfg_sfnm = 1'b0; cfg_master = 1'b0;
        cmd_op = '0; cmd_line = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 out after reset", int'(irq_out), 0);
        chk("R1 line after reset", int'(irq_line), 0);
        cmd(OP_ACK, 0);
        pulse(8'h01);
        expect_irq("R8 ack while idle ignored", 1, 0);
    endtask

    task automatic t_edge;
        do_reset();
        pulse(8'h08);
        expect_irq("R2 pending after fall", 1, 3);
        irq_in[3] = 1'b1; tick(3);
        cmd(OP_ACK, 0);
        expect_irq("R8 ack drops out", 0, 0);
        cmd(OP_EOI, 0);
        expect_irq("R2 held high no new request", 0, 0);
        irq_in[3] = 1'b0; tick(2);
        irq_in[3] = 1'b1; tick(3);
        expect_irq("R2 new rising edge", 1, 3);
        irq_in[3] = 1'b0;
    endtask

    task automatic t_level;
        do_reset();
        trig_level = 8'h10;
        irq_in[4] = 1'b1; tick(3);
        expect_irq("R3 level high", 1, 4);
        irq_in[4] = 1'b0; tick(3);
        expect_irq("R3 level dropped", 0, 0);
        irq_in[4] = 1'b1; tick(3);
        cmd(OP_ACK, 0);
        expect_irq("R6 equal rank blocked", 0, 0);
        cmd(OP_EOI_SPEC, 4);
        expect_irq("R3 level still pending after ack", 1, 4);
        irq_in[4] = 1'b0; tick(2);
    endtask

    task automatic t_mask;
        do_reset();
        mask_we = 1'b1; mask_wdata = 8'h40; tick(1); mask_we = 1'b0; tick(1);
        pulse(8'h40);
        expect_irq("R4 masked quiet", 0, 0);
        mask_we = 1'b1; mask_wdata = 8'h00; tick(1); mask_we = 1'b0; tick(3);
        expect_irq("R4 unmasked raises", 1, 6);
    endtask

    task automatic t_priority;
        do_reset();
        pulse(8'h24);
        expect_irq("R5 offset 0 picks 2", 1, 2);
        cmd(OP_SET_PRI, 3);
        expect_irq("R12 line held", 1, 2);
        cmd(OP_ACK, 0);
        expect_irq("R5 offset 4 picks 5", 1, 5);
    endtask

    task automatic t_inservice;
        do_reset();
        pulse(8'h08);
        cmd(OP_ACK, 0);
        pulse(8'h20);
        expect_irq("R6 lower blocked", 0, 0);
        pulse(8'h08);
        expect_irq("R6 equal blocked", 0, 0);
        pulse(8'h02);
        expect_irq("R6 higher raises", 1, 1);
    endtask

    task automatic t_sfnm;
        do_reset();
        cfg_master = 1'b1;
        pulse(8'h04);
        cmd(OP_ACK, 0);
        pulse(8'h04);
        expect_irq("R7 line 2 blocks without mode", 0, 0);
        cfg_sfnm = 1'b1; tick(3);
        expect_irq("R7 cascade ignored", 1, 2);
        cfg_master = 1'b0; tick(3);
        expect_irq("R7 not master blocks", 0, 0);
    endtask

    task automatic t_aeoi;
        do_reset();
        cfg_auto_eoi = 1'b1; cfg_rot_aeoi = 1'b1;
        pulse(8'h08);
        expect_irq("R9 first request", 1, 3);
        cmd(OP_ACK, 0);
        expect_irq("R9 ack clears", 0, 0);
        pulse(8'h08);
        expect_irq("R9 no in-service mark", 1, 3);
        cmd(OP_ACK, 0);
        pulse(8'h41);
        expect_irq("R9 rotated offset picks 6", 1, 6);
        cmd(OP_ACK, 0);
        expect_irq("R9 next after rotate", 1, 0);
    endtask

    task automatic t_eoi_rot;
        do_reset();
        pulse(8'h02);
        cmd(OP_ACK, 0);
        pulse(8'h40);
        expect_irq("R6 line 6 blocked by 1", 0, 0);
        cmd(OP_EOI_ROT, 0);
        expect_irq("R10 eoi rotate frees 6", 1, 6);
        cmd(OP_ACK, 0);
        pulse(8'h01);
        expect_irq("R10 offset 2 ranks 0 below 6", 0, 0);
        cmd(OP_EOI, 0);
        expect_irq("R10 plain eoi clears 6", 1, 0);
    endtask

    task automatic t_spec;
        do_reset();
        pulse(8'h10);
        cmd(OP_ACK, 0);
        pulse(8'h04);
        expect_irq("R6 2 outranks 4", 1, 2);
        cmd(OP_ACK, 0);
        cmd(OP_EOI_SPEC, 4);
        pulse(8'h88);
        expect_irq("R11 specific eoi kept 2", 0, 0);
        cmd(OP_RSVD, 2);
        expect_irq("R11 reserved no effect", 0, 0);
        cmd(OP_ROT_SPEC, 2);
        expect_irq("R11 specific rotate", 1, 3);
        cmd(OP_ACK, 0);
        pulse(8'h02);
        expect_irq("R11 offset 3 ranks 1 low", 0, 0);
    endtask

    initial begin
        t_reset();
        t_edge();
        t_level();
        t_mask();
        t_priority();
        t_inservice();
        t_sfnm();
        t_aeoi();
        t_eoi_rot();
        t_spec();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule